// File: doc/BRIEF.md
# Paged Open-Drain I/O Port Controller

This block serves 48 open-drain I/O lines, grouped as six 8-bit ports, to a host through an 8-bit register window. The window has sixteen offsets, of which eleven are mapped. Four pages share it. The six port registers, the interrupt summary and the page/lock register appear on every page. Three offsets change meaning with the selected page: they hold per-bit edge polarity, per-bit enable, or per-bit interrupt identification for the first three ports.

A port bit acts as an input or an output through its latch value alone. A latched 1 pulls the pad low. A latched 0 releases the pad, and an external resistor pulls it high. Port reads return the complement of the synchronized pad level. Any port can be frozen against later writes by setting its lock bit. Only reset clears a lock bit. The interrupt request is the OR of every identification bit.

Top module: `paged_io_ctrl`

## Requirements
- R1: After reset, every pad is released (pad_oe_o all 0), the page is 0, all lock bits and interrupt registers are 0, and irq_o is 0.
- R2: A write to offset p (0 to 5) of an unlocked port drives pad_oe_o[8p+7:8p] with the written byte on the next clock; bit value 1 drives the pad low.
- R3: A read of offset p (0 to 5) returns the bitwise complement of pad_in_i[8p+7:8p], delayed by two clocks through a synchronizer; a high pad reads as 0.
- R4: Writing 1 to bit p (5 to 0) of offset 07h locks port p, so later writes to port p leave its output unchanged; other ports stay writable.
- R5: Offset 07h reads back {page[1:0], lock[5:0]}. A write loads the page from bits 7:6 and ORs bits 5:0 into the lock field, so a lock bit never clears until reset.
- R6: Offsets 08h to 0Ah address port 0 to 2 registers chosen by page: page 1 polarity, page 2 enable, page 3 identification. On page 0 they read 00h and ignore writes. Offsets 0Bh to 0Fh read 00h.
- R7: When the enable bit is 1, an edge on the synchronized pad level sets the identification bit. Polarity 1 selects the rising edge and polarity 0 the falling edge. irq_o is the OR of all identification bits.
- R8: Writing 0 to an identification bit clears it. Writing 1 leaves it unchanged.
- R9: Writing 0 to an enable bit clears its identification bit, and the bit stays 0 while the enable is 0.
- R10: Offset 06h is read-only. Bit i (2 to 0) is 1 when port i has any identification bit set, and bits 7:3 read 0.
- R11: If a qualifying edge and a write of 0 to the same identification bit take effect on the same clock, the bit ends up set.
- R12: The port registers, 06h and 07h behave the same on all four pages.
- R13: rdata_o is 00h whenever rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, applied at the clock edge |
| rd_i | input | 1 | Read strobe; read data is combinational |
| rdata_o | output | 8 | Read data, 00h when rd_i is low |
| pad_in_i | input | 48 | Sampled pad levels, port p on bits 8p+7:8p |
| pad_oe_o | output | 48 | Pad pull-down enables, 1 drives the pad low |
| irq_o | output | 1 | Interrupt request |

## Verification
A pad edge that reaches the edge detector and a host write of 0 to the identification register can land on the same clock. When they do, the edge must win. The bench produces this case by moving a pad exactly three edges before a clearing write takes effect, which lines up the detector's set with the write. It then expects the identification byte and the summary to still show the bit. A second collision also gets checked: a lock being set and a write to that port in later cycles. Here the port byte must hold its old value while a neighbouring port accepts its write.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned PIO_NPORT = 6;
  localparam int unsigned PIO_PW    = 8;
  localparam int unsigned PIO_NIRQ  = 3;
  localparam int unsigned PIO_AW    = 4;

  typedef enum logic [1:0] {
    PG_BASE = 2'd0,
    PG_POL  = 2'd1,
    PG_EN   = 2'd2,
    PG_ID   = 2'd3
  } page_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int unsigned W       = 8,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= {W{RST_VAL}};
      s2_q <= {W{RST_VAL}};
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pio_irq_port.sv
module pio_irq_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic         wr_pol_i,
  input  logic         wr_en_i,
  input  logic         wr_id_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] id_o
);
  logic [W-1:0] pol_q, en_q, id_q, prev_q;
  logic [W-1:0] en_d, id_d, hit;

  // edge qualified by polarity and the current enable
  assign hit  = en_q & ((pol_q & pin_i & ~prev_q) | (~pol_q & ~pin_i & prev_q));
  assign en_d = wr_en_i ? wdata_i : en_q;
  // set beats a write-0 clear; a cleared enable forces the bit low
  assign id_d = ((wr_id_i ? (id_q & wdata_i) : id_q) | hit) & en_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q  <= '0;
      en_q   <= '0;
      id_q   <= '0;
      prev_q <= '1;
    end else begin
      if (wr_pol_i) pol_q <= wdata_i;
      en_q   <= en_d;
      id_q   <= id_d;
      prev_q <= pin_i;
    end
  end

  assign pol_o = pol_q;
  assign en_o  = en_q;
  assign id_o  = id_q;
endmodule

// File: rtl/paged_io_ctrl.sv
module paged_io_ctrl
  import pio_pkg::*;
#(
  parameter int unsigned NPORT = PIO_NPORT,
  parameter int unsigned PW    = PIO_PW,
  parameter int unsigned NIRQ  = PIO_NIRQ,
  parameter int unsigned AW    = PIO_AW
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [AW-1:0]       addr_i,
  input  logic [PW-1:0]       wdata_i,
  input  logic                wr_i,
  input  logic                rd_i,
  output logic [PW-1:0]       rdata_o,
  input  logic [NPORT*PW-1:0] pad_in_i,
  output logic [NPORT*PW-1:0] pad_oe_o,
  output logic                irq_o
);
  localparam int unsigned NPIN     = NPORT * PW;
  localparam int unsigned PEND_OFS = NPORT;
  localparam int unsigned PGLK_OFS = NPORT + 1;
  localparam int unsigned IRQ_OFS  = NPORT + 2;

  logic [NPIN-1:0]           pin_s;
  logic [NPORT-1:0]          lock_q;
  page_e                     page_q;
  logic [NIRQ-1:0][PW-1:0]   pol_v, en_v, id_v;
  logic [NIRQ-1:0]           pend;
  logic [PW-1:0]             rd_val;
  logic [PW-1:0]             pglk_rd;

  pio_sync #(.W(NPIN), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (pin_s)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [PW-1:0] lat_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lat_q <= '0;
      else if (wr_i && addr_i == AW'(p) && !lock_q[p]) lat_q <= wdata_i;
    end
    assign pad_oe_o[p*PW +: PW] = lat_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= PG_BASE;
      lock_q <= '0;
    end else if (wr_i && addr_i == AW'(PGLK_OFS)) begin
      page_q <= page_e'(wdata_i[PW-1 -: 2]);
      lock_q <= lock_q | wdata_i[NPORT-1:0];
    end
  end

  for (genvar i = 0; i < NIRQ; i++) begin : g_irq
    logic hit_w;
    assign hit_w = wr_i && addr_i == AW'(IRQ_OFS + i);

    pio_irq_port #(.W(PW)) u_irq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pin_i   (pin_s[i*PW +: PW]),
      .wr_pol_i(hit_w && page_q == PG_POL),
      .wr_en_i (hit_w && page_q == PG_EN),
      .wr_id_i (hit_w && page_q == PG_ID),
      .wdata_i (wdata_i),
      .pol_o   (pol_v[i]),
      .en_o    (en_v[i]),
      .id_o    (id_v[i])
    );

    assign pend[i] = |id_v[i];
  end

  assign irq_o = |pend;

  always_comb begin
    pglk_rd              = '0;
    pglk_rd[PW-1 -: 2]   = page_q;
    pglk_rd[NPORT-1:0]   = lock_q;
  end

  always_comb begin
    rd_val = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (addr_i == AW'(p)) rd_val = ~pin_s[p*PW +: PW];
    end
    if (addr_i == AW'(PEND_OFS)) rd_val[NIRQ-1:0] = pend;
    if (addr_i == AW'(PGLK_OFS)) rd_val = pglk_rd;
    for (int i = 0; i < NIRQ; i++) begin
      if (addr_i == AW'(IRQ_OFS + i)) begin
        unique case (page_q)
          PG_POL:  rd_val = pol_v[i];
          PG_EN:   rd_val = en_v[i];
          PG_ID:   rd_val = id_v[i];
          default: rd_val = '0;
        endcase
      end
    end
  end

  assign rdata_o = rd_i ? rd_val : '0;
endmodule

// File: rtl/pio_chk.sv
module pio_chk #(
  parameter int unsigned NPORT = 6,
  parameter int unsigned PW    = 8,
  parameter int unsigned NIRQ  = 3,
  parameter int unsigned AW    = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [AW-1:0]       addr_i,
  input logic [PW-1:0]       wdata_i,
  input logic                wr_i,
  input logic                rd_i,
  input logic [PW-1:0]       rdata_o,
  input logic [NPORT*PW-1:0] pad_oe_o,
  input logic                irq_o,
  input logic [NPORT-1:0]    lock_i,
  input logic [NIRQ*PW-1:0]  en_i
);
  localparam int unsigned FIRST_FREE = NPORT + 2 + NIRQ;

  // R5
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i & $past(lock_i)) == $past(lock_i));

  for (genvar p = 0; p < NPORT; p++) begin : g_port_chk
    // R4
    locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_i[p] |=> $stable(pad_oe_o[p*PW +: PW]));
    // R2
    port_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == AW'(p) && !lock_i[p]) |=> pad_oe_o[p*PW +: PW] == $past(wdata_i));
  end

  // R10
  pend_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == AW'(NPORT)) |->
      (((rdata_o[NIRQ-1:0] != '0) == irq_o) && (rdata_o[PW-1:NIRQ] == '0)));

  // R6
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i >= AW'(FIRST_FREE)) |-> rdata_o == '0);

  // R7
  irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(en_i != '0));

  // R13
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);
endmodule

bind paged_io_ctrl pio_chk #(.NPORT(NPORT), .PW(PW), .NIRQ(NIRQ), .AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .rdata_o (rdata_o),
  .pad_oe_o(pad_oe_o),
  .irq_o   (irq_o),
  .lock_i  (lock_q),
  .en_i    (en_v)
);

// File: tb/paged_io_ctrl_bench.sv
`timescale 1ns/1ps
module paged_io_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_s = 1'b0;
  logic        rd_s = 1'b0;
  logic [7:0]  rdata;
  logic [47:0] ext = '1;
  logic [47:0] pad_in, pad_oe;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] a;
    logic [7:0] e;
    string      r;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  // open-drain pad: low when driven, else external level
  assign pad_in = ~pad_oe & ext;

  paged_io_ctrl u_paged_io_ctrl (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .addr_i  (addr),
    .wdata_i (wdata),
    .wr_i    (wr_s),
    .rd_i    (rd_s),
    .rdata_o (rdata),
    .pad_in_i(pad_in),
    .pad_oe_o(pad_oe),
    .irq_o   (irq)
  );

  function automatic void check(bit ok, string r, logic [47:0] act, logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endfunction

  always @(negedge clk) begin
    if (rst_n && rd_s) begin
      if (sb.size() == 0) begin
        check(1'b0, "scoreboard-empty", 48'(rdata), 48'h0);
      end else begin
        exp_t it;
        it = sb.pop_front();
        check(rdata === it.e && addr === it.a, it.r, 48'(rdata), 48'(it.e));
      end
    end else if (rst_n && !rd_s) begin
      // R13
      check(rdata === 8'h00, "R13", 48'(rdata), 48'h0);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr_s = 1'b1; rd_s = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string r);
    @(posedge clk); #1;
    addr = a; wr_s = 1'b0; rd_s = 1'b1;
    sb.push_back('{a: a, e: e, r: r});
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      wr_s = 1'b0; rd_s = 1'b0;
    end
  endtask

  task automatic pin(input int b, input logic v);
    @(posedge clk); #1;
    wr_s = 1'b0; rd_s = 1'b0; ext[b] = v;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2);
    // R1
    check(pad_oe === 48'h0, "R1", pad_oe, 48'h0);
    check(irq === 1'b0, "R1", 48'(irq), 48'h0);
    for (int p = 0; p < 6; p++) rd(4'(p), 8'h00, "R1");
    rd(4'h7, 8'h00, "R1");
    rd(4'h6, 8'h00, "R1");

    // R2 / R3
    wr(4'h1, 8'hA5);
    idle(4);
    check(pad_oe[15:8] === 8'hA5, "R2", 48'(pad_oe[15:8]), 48'hA5);
    rd(4'h1, 8'hA5, "R3");
    @(posedge clk); #1; rd_s = 1'b0; ext[23:16] = 8'h0F;
    idle(3);
    rd(4'h2, 8'hF0, "R3");

    // R12 / R5 page field
    wr(4'h7, 8'h80);
    rd(4'h7, 8'h80, "R5");
    rd(4'h1, 8'hA5, "R12");
    rd(4'h2, 8'hF0, "R12");

    // R4 lock
    wr(4'h7, 8'h82);
    wr(4'h1, 8'h00);
    wr(4'h3, 8'h3C);
    idle(2);
    check(pad_oe[15:8] === 8'hA5, "R4", 48'(pad_oe[15:8]), 48'hA5);
    check(pad_oe[31:24] === 8'h3C, "R4", 48'(pad_oe[31:24]), 48'h3C);
    rd(4'h7, 8'h82, "R4");
    wr(4'h7, 8'h40);
    rd(4'h7, 8'h42, "R5");

    // R6 paged window
    wr(4'h7, 8'h00);
    wr(4'h8, 8'hFF);
    rd(4'h8, 8'h00, "R6");
    wr(4'h7, 8'h40);
    rd(4'h8, 8'h00, "R6");
    wr(4'h8, 8'hFF);
    rd(4'h8, 8'hFF, "R6");
    rd(4'hB, 8'h00, "R6");
    rd(4'hF, 8'h00, "R6");

    // R7 rising polarity on port0 bit0
    wr(4'h7, 8'h80);
    wr(4'h8, 8'h01);
    pin(0, 1'b0);
    idle(4);
    check(irq === 1'b0, "R7", 48'(irq), 48'h0);
    pin(0, 1'b1);
    idle(4);
    check(irq === 1'b1, "R7", 48'(irq), 48'h1);
    rd(4'h6, 8'h01, "R10");
    wr(4'h6, 8'hFF);
    rd(4'h6, 8'h01, "R10");
    wr(4'h7, 8'hC0);
    rd(4'h8, 8'h01, "R7");

    // R8 identification clear
    wr(4'h8, 8'h01);
    rd(4'h8, 8'h01, "R8");
    wr(4'h8, 8'h00);
    rd(4'h8, 8'h00, "R8");
    idle(1);
    check(irq === 1'b0, "R8", 48'(irq), 48'h0);

    // R7 falling polarity on port2 bit4
    wr(4'h7, 8'h40);
    wr(4'hA, 8'h00);
    wr(4'h7, 8'h80);
    wr(4'hA, 8'h10);
    pin(20, 1'b1);
    idle(4);
    check(irq === 1'b0, "R7", 48'(irq), 48'h0);
    pin(20, 1'b0);
    idle(4);
    check(irq === 1'b1, "R7", 48'(irq), 48'h1);
    rd(4'h6, 8'h04, "R10");
    wr(4'h7, 8'hC0);
    rd(4'hA, 8'h10, "R7");

    // R9 enable clear
    wr(4'h7, 8'h80);
    wr(4'hA, 8'h00);
    idle(1);
    check(irq === 1'b0, "R9", 48'(irq), 48'h0);
    wr(4'h7, 8'hC0);
    rd(4'hA, 8'h00, "R9");
    pin(20, 1'b1);
    idle(4);
    pin(20, 1'b0);
    idle(4);
    rd(4'hA, 8'h00, "R9");
    idle(1);
    check(irq === 1'b0, "R9", 48'(irq), 48'h0);

    // R11 edge set and write clear on the same edge
    pin(0, 1'b0);
    idle(4);
    pin(0, 1'b1);
    idle(1);
    wr(4'h8, 8'h00);
    idle(1);
    rd(4'h8, 8'h01, "R11");
    idle(1);
    check(irq === 1'b1, "R11", 48'(irq), 48'h1);
    wr(4'h8, 8'h00);
    rd(4'h8, 8'h00, "R8");
    idle(3);
    check(sb.size() == 0, "scoreboard-drain", 48'(sb.size()), 48'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule